// File: doc/BRIEF.md
# Constant-Weight Coded Mealy Controller

This block is a four-state synchronous Mealy controller whose every observable word is protected by a constant-weight code. The state is held in one-hot form. The five functional outputs are widened by two check bits so that a healthy 7-bit output word always carries exactly three ones. A single fault inside the next-state or output logic, or in the state flops, therefore produces a word of the wrong weight, and an external weight checker can flag it.

Each output and next-state line is the OR of per-state product terms, each gated by its own state bit, so the logic is monotone in the state bits. If the register holds a word that is not a code word, the output follows a fixed rule. An all-zero state drives every line to zero. A multi-hot state drives the bitwise OR of the words that the individual states would produce.

The register does not feed itself. Every cycle it loads whatever next-state value arrives on the load port. A surrounding wrapper can then choose between this block's next-state lines and those of a spare copy before writing them back.

Top module: `scfsm_coded`

## Requirements
- R1: While `rst_i` is high at a rising edge, the state register takes the code 4'b0001 (state 1, held in bit 0). Immediately after reset, with `x_i`=3'b000, the block shows `nxt_o`=4'b0001, `func_o`=5'b00010 and `chk_o`=2'b11.
- R2: In state 1 (state code 4'b0001), with `x_i[2]`=x1, `x_i[1]`=x2 and `x_i[0]`=x3, the block advances when x1 and x2 are both 1: `nxt_o`=4'b0010 and `func_o`=5'b10010. In every other case it holds: `nxt_o`=4'b0001 and `func_o`=5'b00010. `func_o[4]` is y1 and `func_o[0]` is y5.
- R3: In state 2 (4'b0010), x3=1 advances the machine with `nxt_o`=4'b0100 and `func_o`=5'b10110. x3=0 holds it with `nxt_o`=4'b0010 and `func_o`=5'b00110.
- R4: In state 3 (4'b0100), x1=1 with x2=0 holds the machine with `nxt_o`=4'b0100 and `func_o`=5'b01000. Any other input advances it with `nxt_o`=4'b1000 and `func_o`=5'b11000.
- R5: In state 4 (4'b1000), x3=1 advances the machine with `nxt_o`=4'b0001 and `func_o`=5'b11001. x3=0 holds it with `nxt_o`=4'b1000 and `func_o`=5'b01001.
- R6: The check bits `chk_o[1]` (y6) and `chk_o[0]` (y7) make up the ones that `func_o` lacks to reach weight 3, filling y6 first. A functional weight of 1 gives 2'b11, 2 gives 2'b10 and 3 gives 2'b00. For every one-hot state and every input, {`func_o`,`chk_o`} has exactly three ones.
- R7: Whenever the state is one-hot, `nxt_o` is one-hot.
- R8: Outside reset, the state register loads `ld_state_i` at every rising edge, whatever value `nxt_o` shows.
- R9: An all-zero state drives `nxt_o`, `func_o` and `chk_o` to zero. A multi-hot state drives, on each line, the bitwise OR of the words its set bits would produce alone. For example, state 4'b0011 with `x_i`=3'b000 gives `nxt_o`=4'b0011, `func_o`=5'b00110 and `chk_o`=2'b11.
- R10: Reset has priority over the load port: a code on `ld_state_i` during reset is not taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_i | input | 1 | Synchronous active-high reset |
| x_i | input | 3 | Inputs x1 (bit 2), x2 (bit 1), x3 (bit 0) |
| ld_state_i | input | 4 | Next state to write into the register |
| func_o | output | 5 | Functional outputs y1 (bit 4) to y5 (bit 0) |
| chk_o | output | 2 | Check bits y6 (bit 1), y7 (bit 0) |
| nxt_o | output | 4 | Next-state lines, one-hot when healthy |

## Verification
In every one-hot state, all eight input combinations are applied and compared against the transition table. This separates the hold branch from the advance branch of each state and confirms that the unused input bits have no effect. The walk feeds the expected next state back through the load port, so every transition of the cycle is reached. Loading a state that differs from `nxt_o` shows that the register follows the port rather than its own logic. Loading the all-zero and two-hot words exposes the monotone OR behaviour that lets an external checker catch a wrong weight.

// File: rtl/scfsm_pkg.sv
package scfsm_pkg;
  localparam int NS     = 4;   // states, one-hot
  localparam int NX     = 3;   // primary inputs
  localparam int NY     = 5;   // functional outputs
  localparam int NC     = 2;   // check outputs
  localparam int CODE_W = 3;   // weight of a healthy output word
  localparam int WW     = $clog2(NY + 1);

  localparam logic [NS-1:0] RESET_CODE = NS'(1);

  // check bits for a functional word of weight w, filling the upper bit first
  function automatic logic [NC-1:0] fill_bits(input logic [WW-1:0] w);
    logic [NC-1:0] r;
    r = '0;
    for (int i = 0; i < NC; i++) begin
      if (int'(w) + i < CODE_W) r[NC-1-i] = 1'b1;
    end
    return r;
  endfunction
endpackage

// File: rtl/scfsm_term.sv
module scfsm_term
  import scfsm_pkg::*;
#(
  parameter int IDX = 0
) (
  input  logic          act_i,
  input  logic [NX-1:0] x_i,
  output logic [NS-1:0] nxt_o,
  output logic [NY-1:0] func_o,
  output logic [NC-1:0] chk_o
);
  logic          x1, x2, x3;
  logic          adv;
  logic [NY-2:0] base;
  logic [NY-1:0] word;
  logic [WW-1:0] wt;

  assign x1 = x_i[2];
  assign x2 = x_i[1];
  assign x3 = x_i[0];

  generate
    if (IDX == 0) begin : g_s1
      assign adv  = x1 & x2;
      assign base = 4'b0010;
    end else if (IDX == 1) begin : g_s2
      assign adv  = x3;
      assign base = 4'b0110;
    end else if (IDX == 2) begin : g_s3
      assign adv  = ~x1 | x2;
      assign base = 4'b1000;
    end else begin : g_s4
      assign adv  = x3;
      assign base = 4'b1001;
    end
  endgenerate

  // y1 marks a move to the following state
  assign word = {adv, base};

  always_comb begin
    wt = '0;
    for (int i = 0; i < NY; i++) wt = wt + WW'(word[i]);
  end

  localparam int NEXT_IDX = (IDX + 1) % NS;

  always_comb begin
    nxt_o = '0;
    if (act_i) begin
      if (adv) nxt_o[NEXT_IDX] = 1'b1;
      else     nxt_o[IDX]      = 1'b1;
    end
  end

  assign func_o = act_i ? word : '0;
  assign chk_o  = act_i ? fill_bits(wt) : '0;
endmodule

// File: rtl/scfsm_state_reg.sv
module scfsm_state_reg
  import scfsm_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_i,
  input  logic [NS-1:0] d_i,
  output logic [NS-1:0] q_o
);
  always_ff @(posedge clk_i) begin
    if (rst_i) q_o <= RESET_CODE;
    else       q_o <= d_i;
  end
endmodule

// File: rtl/scfsm_coded.sv
module scfsm_coded
  import scfsm_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_i,
  input  logic [NX-1:0] x_i,
  input  logic [NS-1:0] ld_state_i,
  output logic [NY-1:0] func_o,
  output logic [NC-1:0] chk_o,
  output logic [NS-1:0] nxt_o
);
  logic [NS-1:0] state_q;
  logic [NS-1:0] t_nxt  [NS];
  logic [NY-1:0] t_func [NS];
  logic [NC-1:0] t_chk  [NS];

  scfsm_state_reg u_reg (
    .clk_i (clk_i),
    .rst_i (rst_i),
    .d_i   (ld_state_i),
    .q_o   (state_q)
  );

  for (genvar s = 0; s < NS; s++) begin : g_term
    scfsm_term #(.IDX(s)) u_term (
      .act_i  (state_q[s]),
      .x_i    (x_i),
      .nxt_o  (t_nxt[s]),
      .func_o (t_func[s]),
      .chk_o  (t_chk[s])
    );
  end

  // monotone merge: each line is the OR of its state-gated terms
  always_comb begin
    nxt_o  = '0;
    func_o = '0;
    chk_o  = '0;
    for (int s = 0; s < NS; s++) begin
      nxt_o  = nxt_o  | t_nxt[s];
      func_o = func_o | t_func[s];
      chk_o  = chk_o  | t_chk[s];
    end
  end
endmodule

// File: rtl/scfsm_coded_chk.sv
module scfsm_coded_chk
  import scfsm_pkg::*;
(
  input logic          clk_i,
  input logic          rst_i,
  input logic [NX-1:0] x_i,
  input logic [NS-1:0] ld_state_i,
  input logic [NS-1:0] state_q,
  input logic [NY-1:0] func_o,
  input logic [NC-1:0] chk_o,
  input logic [NS-1:0] nxt_o
);
  AST_RESET_CODE: assert property (@(posedge clk_i) disable iff (rst_i)
    $past(rst_i) |-> state_q == RESET_CODE); // R1

  AST_S1_ADVANCE: assert property (@(posedge clk_i) disable iff (rst_i)
    (state_q == 4'b0001 && x_i[2] && x_i[1]) |-> (nxt_o == 4'b0010 && func_o == 5'b10010)); // R2

  AST_S2_HOLD: assert property (@(posedge clk_i) disable iff (rst_i)
    (state_q == 4'b0010 && !x_i[0]) |-> (nxt_o == 4'b0010 && func_o == 5'b00110)); // R3

  AST_CODE_WEIGHT: assert property (@(posedge clk_i) disable iff (rst_i)
    $onehot(state_q) |-> $countones({func_o, chk_o}) == CODE_W); // R6

  AST_NEXT_ONEHOT: assert property (@(posedge clk_i) disable iff (rst_i)
    $onehot(state_q) |-> $onehot(nxt_o)); // R7

  AST_LOAD_FOLLOWS: assert property (@(posedge clk_i) disable iff (rst_i)
    !$past(rst_i) |-> state_q == $past(ld_state_i)); // R8

  AST_ZERO_STATE: assert property (@(posedge clk_i) disable iff (rst_i)
    (state_q == '0) |-> (nxt_o == '0 && func_o == '0 && chk_o == '0)); // R9
endmodule

bind scfsm_coded scfsm_coded_chk u_chk (
  .clk_i      (clk_i),
  .rst_i      (rst_i),
  .x_i        (x_i),
  .ld_state_i (ld_state_i),
  .state_q    (state_q),
  .func_o     (func_o),
  .chk_o      (chk_o),
  .nxt_o      (nxt_o)
);

// File: tb/scfsm_coded_tb.sv
module scfsm_coded_tb;
  logic       clk_i = 1'b0;
  logic       rst_i = 1'b1;
  logic [2:0] x_i = 3'b000;
  logic [3:0] ld_state_i = 4'b0001;
  logic [4:0] func_o;
  logic [1:0] chk_o;
  logic [3:0] nxt_o;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #4 clk_i = ~clk_i;

  scfsm_coded u_dut (
    .clk_i      (clk_i),
    .rst_i      (rst_i),
    .x_i        (x_i),
    .ld_state_i (ld_state_i),
    .func_o     (func_o),
    .chk_o      (chk_o),
    .nxt_o      (nxt_o)
  );

  // expected {nxt, func, chk} built from the transition table, ORed over set state bits
  function automatic logic [10:0] model(input logic [3:0] s, input logic [2:0] x);
    logic [10:0] acc;
    logic adv;
    acc = '0;
    if (s[0]) begin
      adv = x[2] & x[1];
      acc = acc | {adv ? 4'b0010 : 4'b0001, adv, 4'b0010, adv ? 2'b10 : 2'b11};
    end
    if (s[1]) begin
      adv = x[0];
      acc = acc | {adv ? 4'b0100 : 4'b0010, adv, 4'b0110, adv ? 2'b00 : 2'b10};
    end
    if (s[2]) begin
      adv = ~x[2] | x[1];
      acc = acc | {adv ? 4'b1000 : 4'b0100, adv, 4'b1000, adv ? 2'b10 : 2'b11};
    end
    if (s[3]) begin
      adv = x[0];
      acc = acc | {adv ? 4'b0001 : 4'b1000, adv, 4'b1001, adv ? 2'b00 : 2'b10};
    end
    return acc;
  endfunction

  task automatic check(input string req, input logic [10:0] act, input logic [10:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic clock_in(input logic [3:0] ld);
    ld_state_i = ld;
    @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic t_reset();
    // R10: load port carries state 3 during reset and must be ignored
    rst_i = 1'b1;
    ld_state_i = 4'b0100;
    repeat (2) @(posedge clk_i);
    @(negedge clk_i);
    x_i = 3'b000;
    #1;
    check("R1", {nxt_o, func_o, chk_o}, {4'b0001, 5'b00010, 2'b11});
    check("R10", {nxt_o, func_o, chk_o}, model(4'b0001, 3'b000));
    rst_i = 1'b0;
    ld_state_i = 4'b0001;
  endtask

  task automatic t_walk();
    logic [3:0] s;
    logic [2:0] adv_x [4];
    string reqs [4];
    adv_x[0] = 3'b110; adv_x[1] = 3'b001; adv_x[2] = 3'b000; adv_x[3] = 3'b001;
    reqs[0] = "R2"; reqs[1] = "R3"; reqs[2] = "R4"; reqs[3] = "R5";
    s = 4'b0001;
    for (int k = 0; k < 4; k++) begin
      for (int v = 0; v < 8; v++) begin
        x_i = 3'(v);
        #1;
        check(reqs[k], {nxt_o, func_o, chk_o}, model(s, 3'(v)));
        check("R6", 11'($countones({func_o, chk_o})), 11'd3);
        check("R7", 11'($onehot(nxt_o)), 11'd1);
      end
      x_i = adv_x[k];
      #1;
      s = model(s, adv_x[k])[10:7];
      clock_in(s);
    end
    // back in state 1 after a full cycle
    x_i = 3'b000;
    #1;
    check("R5", {nxt_o, func_o, chk_o}, {4'b0001, 5'b00010, 2'b11});
  endtask

  task automatic t_load_override();
    // R8: nxt_o shows 0001, but the port loads state 4
    x_i = 3'b000;
    clock_in(4'b1000);
    #1;
    check("R8", {nxt_o, func_o, chk_o}, {4'b1000, 5'b01001, 2'b10});
    clock_in(4'b0010);
    #1;
    check("R8", {nxt_o, func_o, chk_o}, {4'b0010, 5'b00110, 2'b10});
  endtask

  task automatic t_noncode();
    clock_in(4'b0000);
    for (int v = 0; v < 8; v += 3) begin
      x_i = 3'(v);
      #1;
      check("R9", {nxt_o, func_o, chk_o}, 11'b0);
    end
    x_i = 3'b000;
    clock_in(4'b0011);
    #1;
    check("R9", {nxt_o, func_o, chk_o}, {4'b0011, 5'b00110, 2'b11});
    x_i = 3'b111;
    clock_in(4'b1100);
    #1;
    check("R9", {nxt_o, func_o, chk_o}, model(4'b1100, 3'b111));
    check("R9", {nxt_o, func_o, chk_o}, {4'b1001, 5'b11001, 2'b10});
    clock_in(4'b0001);
  endtask

  initial begin
    @(negedge clk_i);
    t_reset();
    t_walk();
    t_load_override();
    t_noncode();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    #(8 * 100000);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule